// File: doc/BRIEF.md
# Tick-Paced Six-Lamp Temperature and Trend Indicator

This block drives a row of six lamps from a single-cycle tick strobe, typically the pulse of a periodic interval timer. Between ticks the lamp pattern is held. On each tick the block computes one new frame, either a direct picture of a temperature reading or one step of a trend animation.

In value mode the low five lamps carry the temperature code and the top lamp marks the unit (lit for Celsius, dark for Fahrenheit). In trend mode the lamps animate: a steady trend blinks the whole row, a rising trend walks one lit lamp toward the top bit, and a falling trend walks it toward the bottom bit. Each animation opens with an all-dark frame. Any change of mode or trend code restarts the animation from that dark frame. The block does not convert units or read a sensor. Both the unit flag and the temperature code arrive already formed.

Top module: `led_trend_disp`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `led_o` is 0x00.
- R2: `led_o` changes only at a clock edge where `tick_i` is 1. In every other cycle it holds its value.
- R3: On a tick with `value_mode_i` = 1, the next frame is {`celsius_i`, `temp_i`}: bit 5 is 1 for Celsius and 0 for Fahrenheit, and bits 4..0 equal `temp_i`. All of these are sampled at that tick.
- R4: Trend codes on `trend_i` are: 2'b00 steady, 2'b01 rising, 2'b10 falling. Code 2'b11 behaves as steady.
- R5: On a tick with `value_mode_i` = 0, the frame is 0x00 in each of these cases: it is the first tick since reset; `value_mode_i` differs from its value at the previous tick; or `trend_i` differs from its code at the previous tick.
- R6: For steady, each further tick gives the bitwise inverse of the current frame (0x3F minus it), so the row blinks 0x00, 0x3F, 0x00, and so on.
- R7: For rising, frames follow 0x00, 0x01, 0x02, 0x04, 0x08, 0x10, 0x20 and then return to 0x00 and repeat.
- R8: For falling, frames follow 0x00, 0x20, 0x10, 0x08, 0x04, 0x02, 0x01 and then return to 0x00 and repeat.
- R9: In trend mode, `celsius_i` and `temp_i` have no effect on the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle update strobe |
| value_mode_i | input | 1 | 1 selects value display, 0 selects trend animation |
| celsius_i | input | 1 | Unit flag shown on the top lamp in value mode |
| temp_i | input | VAL_W (5) | Temperature code shown in value mode |
| trend_i | input | 2 | Trend code (00 steady, 01 rising, 10 falling, 11 steady) |
| led_o | output | LED_W (6) | Lamp pattern |

## Verification
The assertions assume that `tick_i` is a plain synchronous strobe, that `trend_i`, `value_mode_i`, `celsius_i` and `temp_i` are stable around the clock edge, and that the top lamp width is one more than the temperature width. The stimulus drives every input on the falling clock edge. It uses only the default widths. It mixes directed runs with long stretches of random ticks, modes, codes and temperatures, so that every restart cause and every wrap point is reached.

// File: rtl/led_trend_pkg.sv
package led_trend_pkg;
   typedef enum logic [1:0] {
      TREND_FLAT = 2'b00,
      TREND_UP   = 2'b01,
      TREND_DOWN = 2'b10,
      TREND_ALT  = 2'b11
   } trend_e;
endpackage

// File: rtl/led_trend_step.sv
module led_trend_step
   import led_trend_pkg::*;
#(
   parameter int LED_W = 6
) (
   input  logic [LED_W-1:0] cur_i,
   input  trend_e           trend_i,
   input  logic             restart_i,
   output logic [LED_W-1:0] nxt_o
);
   logic             dark;
   logic [LED_W-1:0] up_f;
   logic [LED_W-1:0] dn_f;

   assign dark = (cur_i == '0);

   for (genvar b = 0; b < LED_W; b++) begin : g_bit
      if (b == 0) begin : g_low
         assign up_f[b] = dark;
      end else begin : g_up
         assign up_f[b] = cur_i[b-1];
      end
      if (b == LED_W - 1) begin : g_high
         assign dn_f[b] = dark;
      end else begin : g_dn
         assign dn_f[b] = cur_i[b+1];
      end
   end

   always_comb begin
      if (restart_i) begin
         nxt_o = '0;
      end else begin
         unique case (trend_i)
            TREND_UP:   nxt_o = up_f;
            TREND_DOWN: nxt_o = dn_f;
            default:    nxt_o = ~cur_i;
         endcase
      end
   end
endmodule

// File: rtl/led_trend_track.sv
module led_trend_track
   import led_trend_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   tick_i,
   input  logic   mode_i,
   input  trend_e trend_i,
   output logic   restart_o
);
   logic   seen_q;
   logic   mode_q;
   trend_e trend_q;

   assign restart_o = !seen_q || (mode_i != mode_q) || (trend_i != trend_q);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         seen_q  <= 1'b0;
         mode_q  <= 1'b0;
         trend_q <= TREND_FLAT;
      end else if (tick_i) begin
         seen_q  <= 1'b1;
         mode_q  <= mode_i;
         trend_q <= trend_i;
      end
   end
endmodule

// File: rtl/led_value_fmt.sv
module led_value_fmt #(
   parameter int LED_W = 6,
   parameter int VAL_W = 5
) (
   input  logic             unit_i,
   input  logic [VAL_W-1:0] val_i,
   output logic [LED_W-1:0] frame_o
);
   localparam int PAD_W = LED_W - 1 - VAL_W;

   if (PAD_W == 0) begin : g_tight
      assign frame_o = {unit_i, val_i};
   end else begin : g_padded
      assign frame_o = {unit_i, {PAD_W{1'b0}}, val_i};
   end
endmodule

// File: rtl/led_trend_disp.sv
module led_trend_disp
   import led_trend_pkg::*;
#(
   parameter int LED_W = 6,
   parameter int VAL_W = LED_W - 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             value_mode_i,
   input  logic             celsius_i,
   input  logic [VAL_W-1:0] temp_i,
   input  logic [1:0]       trend_i,
   output logic [LED_W-1:0] led_o
);
   initial begin
      assert (LED_W >= 2 && VAL_W >= 1 && VAL_W + 1 <= LED_W)
         else $error("led_trend_disp: VAL_W must leave one lamp for the unit flag");
   end

   trend_e           trend;
   logic             restart;
   logic [LED_W-1:0] step_frame;
   logic [LED_W-1:0] val_frame;
   logic [LED_W-1:0] led_q;

   assign trend = trend_e'(trend_i);

   led_trend_track u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .mode_i    (value_mode_i),
      .trend_i   (trend),
      .restart_o (restart)
   );

   led_trend_step #(.LED_W(LED_W)) u_step (
      .cur_i     (led_q),
      .trend_i   (trend),
      .restart_i (restart),
      .nxt_o     (step_frame)
   );

   led_value_fmt #(.LED_W(LED_W), .VAL_W(VAL_W)) u_fmt (
      .unit_i  (celsius_i),
      .val_i   (temp_i),
      .frame_o (val_frame)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         led_q <= '0;
      end else if (tick_i) begin
         led_q <= value_mode_i ? val_frame : step_frame;
      end
   end

   assign led_o = led_q;
endmodule

// File: rtl/led_trend_disp_chk.sv
module led_trend_disp_chk #(
   parameter int LED_W = 6,
   parameter int VAL_W = LED_W - 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick_i,
   input logic             value_mode_i,
   input logic             celsius_i,
   input logic [VAL_W-1:0] temp_i,
   input logic [1:0]       trend_i,
   input logic [LED_W-1:0] led_o
);
   logic       c_seen;
   logic       c_mode;
   logic [1:0] c_trend;
   logic       c_restart;
   logic       anim;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         c_seen  <= 1'b0;
         c_mode  <= 1'b0;
         c_trend <= 2'b00;
      end else if (tick_i) begin
         c_seen  <= 1'b1;
         c_mode  <= value_mode_i;
         c_trend <= trend_i;
      end
   end

   assign c_restart = !c_seen || (c_mode != value_mode_i) || (c_trend != trend_i);
   assign anim      = tick_i && !value_mode_i;

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(led_o)); // R2

   AST_VALUE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && value_mode_i) |=> (led_o == {$past(celsius_i), $past(temp_i)})); // R3

   AST_RESTART_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (anim && c_restart) |=> (led_o == '0)); // R5

   AST_FLAT_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (anim && !c_restart && (trend_i == 2'b00 || trend_i == 2'b11))
      |=> (led_o == ~$past(led_o))); // R6

   AST_RUN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (anim && (trend_i == 2'b01 || trend_i == 2'b10)) |=> $onehot0(led_o)); // R7

   AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (anim && !c_restart && trend_i == 2'b01)
      |=> (($past(led_o) == '0) ? (led_o == LED_W'(1))
                                : (led_o == LED_W'($past(led_o) << 1)))); // R7

   AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (anim && !c_restart && trend_i == 2'b10)
      |=> (($past(led_o) == '0) ? (led_o == LED_W'(1) << (LED_W - 1))
                                : (led_o == ($past(led_o) >> 1)))); // R8
endmodule

bind led_trend_disp led_trend_disp_chk #(.LED_W(LED_W), .VAL_W(VAL_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .tick_i       (tick_i),
   .value_mode_i (value_mode_i),
   .celsius_i    (celsius_i),
   .temp_i       (temp_i),
   .trend_i      (trend_i),
   .led_o        (led_o)
);

// File: tb/led_trend_disp_tb_top.sv
`timescale 1ns/1ps
module led_trend_disp_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       vmode = 1'b0;
   logic       cel = 1'b0;
   logic [4:0] temp = '0;
   logic [1:0] trend = '0;
   logic [5:0] led;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   int ref_led = 0;
   bit ref_seen = 0;
   int ref_mode = 0;
   int ref_trend = 0;

   always #2.5 clk = ~clk;

   led_trend_disp dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .value_mode_i(vmode),
      .celsius_i(cel), .temp_i(temp), .trend_i(trend), .led_o(led)
   );

   task automatic check(string req, int exp);
      n_chk++;
      if (int'(led) != exp) begin
         n_fail++;
         $display("FAIL %s: led=0x%02h expected=0x%02h at %0t", req, led, exp, $time);
      end
   endtask

   // One clock: inputs already applied; model the edge, then compare at the next falling edge.
   task automatic cyc(bit t, bit vm, bit c, int tv, int tr, string tag_in = "");
      string tag;
      tick = t; vmode = vm; cel = c; temp = 5'(tv); trend = 2'(tr);
      tag = "R2";
      if (!rst_n) begin
         ref_led = 0; ref_seen = 0; ref_mode = 0; ref_trend = 0; tag = "R1";
      end else if (t) begin
         if (vm) begin
            ref_led = (c ? 32 : 0) + tv; tag = "R3";
         end else if (!ref_seen || ref_mode != 0 || ref_trend != tr) begin
            ref_led = 0; tag = "R5";
         end else if (tr == 1) begin
            ref_led = (ref_led == 0) ? 1 : ref_led * 2;
            if (ref_led >= 64) ref_led = 0;
            tag = "R7";
         end else if (tr == 2) begin
            ref_led = (ref_led == 0) ? 32 : ref_led / 2;
            tag = "R8";
         end else begin
            ref_led = 63 - ref_led;
            tag = (tr == 3) ? "R4" : "R6";
         end
         ref_seen = 1; ref_mode = vm; ref_trend = tr;
      end
      if (tag_in != "") tag = tag_in;
      @(negedge clk);
      check(tag, ref_led);
   endtask

   initial begin
      @(negedge clk);
      // R1: reset holds the row dark even with ticks present
      for (int i = 0; i < 3; i++) cyc(1, 1, 1, 17, 0, "R1");
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 1, "R1");
      // R7 rising with wrap, then R2 holds between ticks
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 1);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1);
      // R9: temperature and unit toggling do not disturb the rising walk
      for (int i = 0; i < 8; i++) cyc(1, 0, i[0], i * 3, 1, i == 0 ? "" : "R9");
      // R5 code change, R8 falling with wrap
      for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 2);
      // R6 steady blink, R4 code 3 as steady
      for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 3);
      // R3 value display: Celsius 24, Fahrenheit 3, extremes
      cyc(1, 1, 1, 24, 0);
      cyc(1, 1, 0, 3, 0);
      cyc(1, 1, 1, 31, 0);
      cyc(1, 1, 0, 0, 0);
      cyc(0, 1, 1, 9, 0);
      // R5 return to trend mode restarts dark
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 1);
      // mixed random stretch
      for (int i = 0; i < 2000; i++)
         cyc(($urandom % 3) != 0, ($urandom % 8) == 0, 1'($urandom), int'($urandom % 32),
             ($urandom % 6 == 0) ? int'($urandom % 4) : ref_trend);
      // R1 reset in the middle of a walk
      rst_n = 1'b0;
      cyc(1, 0, 0, 0, 1, "R1");
      rst_n = 1'b1;
      cyc(1, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 1);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule